// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of four DMA channels gets the system bus next. When at least one request that is not masked is waiting, it raises a hold request to the host. Once the host returns hold acknowledge, it picks one waiting channel and drives that channel's active-low acknowledge. The acknowledge stays on until the transfer engine pulses service done. If requests are still waiting at that point, the block arbitrates again without giving up the bus. If none are waiting, it drops the hold request and waits for the host to release hold acknowledge before it can ask again.

The winner is chosen in one of two ways. In fixed order the lowest channel number always wins. In rotating order the channel that was just served moves to the bottom of the order. A configuration write loads the per-channel mask bits and the ordering mode in the same cycle.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `hrq` is low, every bit of `ack_n` is high, all four channels are masked, fixed order is selected and the rotation pointer points at channel 0.
- R2: When the block is idle, hold acknowledge is low and an unmasked request is present, `hrq` goes high one cycle later. No `ack_n` bit goes low until `hlda` is high.
- R3: In fixed order (`cfg_rotate`=0), the waiting unmasked channel with the lowest index wins.
- R4: In rotating order (`cfg_rotate`=1), completing service of channel c sets the order to c+1, c+2, ... with c last. The pointer moves only on services completed in rotating order. Fixed order ignores it.
- R5: A grant is held, with `gnt_idx` and `ack_n` unchanged, until `svc_done`. A higher-priority request that arrives meanwhile does not preempt it.
- R6: If no unmasked request remains at `svc_done`, `hrq` falls. While `hlda` stays high after that, `hrq` stays low even if new requests arrive.
- R7: A `cfg_we` pulse loads `cfg_mask` (bit n = 1 masks channel n) and `cfg_rotate`. A masked channel is never granted, and masked requests alone never raise `hrq`.
- R8: At most one `ack_n` bit is low at any time, and it is bit `gnt_idx`. All bits are high whenever `hlda` is low, including in the middle of a service.
- R9: If unmasked requests remain at `svc_done`, `hrq` stays high and the next grant follows after a single arbitration cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the mask and ordering mode |
| cfg_mask | input | 4 | Per-channel mask value, 1 = masked |
| cfg_rotate | input | 1 | Ordering mode: 1 = rotating, 0 = fixed |
| dreq | input | 4 | Channel request lines, active high |
| hlda | input | 1 | Hold acknowledge from the host |
| svc_done | input | 1 | One-cycle strobe: the current service is complete |
| hrq | output | 1 | Hold request to the host |
| gnt_idx | output | 2 | Index of the granted channel |
| ack_n | output | 4 | Per-channel acknowledge, active low |

## Verification
A corrupted rotation pointer or mask register does not show up until the next arbitration. It then appears as a grant out of the expected order, so the scoreboard compares every grant against a hand-derived sequence, both in rotating runs with requests held continuously and in runs where served requests are dropped. A controller state that leaves service too early, or never enters it, shows within a cycle on `ack_n` or `gnt_idx` while the engine is still counting. It can also appear as `hrq` falling between back-to-back services. Hold-handshake faults show within one or two cycles as an acknowledge without `hlda`, or as a new hold request raised while the host still holds the bus.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [NCH-1:0] cfg_mask,
  input  logic           cfg_rotate,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  input  logic           svc_done,
  output logic           hrq,
  output logic [IW-1:0]  gnt_idx,
  output logic [NCH-1:0] ack_n
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_HOLD = 2'd1, ST_SERVE = 2'd2, ST_DRAIN = 2'd3} st_t;

  st_t            st;
  logic [NCH-1:0] mask_q;
  logic           rot_q;
  logic [IW-1:0]  top_q;
  logic [IW-1:0]  gnt_q;
  logic [NCH-1:0] pend;
  logic [IW-1:0]  base;
  logic [IW-1:0]  win;
  logic           any_pend;

  assign pend     = dreq & ~mask_q;
  assign any_pend = |pend;
  assign base     = rot_q ? top_q : '0;

  always_comb begin
    win = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pend[(int'(base) + k) % NCH]) win = IW'((int'(base) + k) % NCH);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      rot_q  <= 1'b0;
    end else if (cfg_we) begin
      mask_q <= cfg_mask;
      rot_q  <= cfg_rotate;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      gnt_q <= '0;
      top_q <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (any_pend && !hlda) st <= ST_HOLD;
        ST_HOLD: begin
          if (!any_pend) st <= ST_DRAIN;
          else if (hlda) begin
            st    <= ST_SERVE;
            gnt_q <= win;
          end
        end
        ST_SERVE: begin
          if (svc_done) begin
            if (rot_q) top_q <= (int'(gnt_q) == NCH - 1) ? '0 : gnt_q + IW'(1);
            st <= any_pend ? ST_HOLD : ST_DRAIN;
          end
        end
        default:  if (!hlda) st <= ST_IDLE;
      endcase
    end
  end

  assign hrq     = (st == ST_HOLD) || (st == ST_SERVE);
  assign gnt_idx = gnt_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ack
      assign ack_n[c] = !((st == ST_SERVE) && hlda && (gnt_q == IW'(c)));
    end
  endgenerate

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hlda,
  input logic           hrq,
  input logic [IW-1:0]  gnt_idx,
  input logic [NCH-1:0] ack_n,
  input logic           svc_done,
  input logic [1:0]     st,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] dreq
);

  logic [1:0]     st_d;
  logic [NCH-1:0] mask_d;
  logic [NCH-1:0] req_d;
  logic           fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_d   <= 2'd0;
      mask_d <= '1;
      req_d  <= '0;
    end else begin
      st_d   <= st;
      mask_d <= mask_q;
      req_d  <= dreq;
    end
  end

  assign fresh = (st == 2'd2) && (st_d == 2'd1);

  // R8
  one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ack_n));
  // R8
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !hlda |-> (&ack_n));
  // R8
  ack_idx_chk: assert property (@(posedge clk) disable iff (!rst_n) !(&ack_n) |-> !ack_n[gnt_idx]);
  // R2
  ack_needs_hrq_chk: assert property (@(posedge clk) disable iff (!rst_n) !hrq |-> (&ack_n));
  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&ack_n) && !svc_done) |=> $stable(gnt_idx));
  // R6
  no_rereq_chk: assert property (@(posedge clk) disable iff (!rst_n) (!hrq && hlda) |=> !hrq);
  // R7
  masked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (!mask_d[gnt_idx] && req_d[gnt_idx]));

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hlda(hlda), .hrq(hrq), .gnt_idx(gnt_idx),
  .ack_n(ack_n), .svc_done(svc_done), .st(st), .mask_q(mask_q), .dreq(dreq)
);

// File: tb/dma_prio_arb_tb.sv
`timescale 1ns/1ps
module dma_prio_arb_tb;
  localparam int NCH = 4;
  localparam int SVC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NCH-1:0] req_on = '0;
  logic [NCH-1:0] served_clr;
  logic [NCH-1:0] dreq;
  logic [NCH-1:0] cfg_mask = '1;
  logic           cfg_we = 1'b0, cfg_rotate = 1'b0;
  logic           hlda, svc_done;
  logic           host_auto = 1'b1, hlda_force = 1'b0, drop_mode = 1'b1, clr_flush = 1'b0;
  logic           hrq;
  logic [1:0]     gnt_idx;
  logic [NCH-1:0] ack_n;

  assign dreq = req_on & ~served_clr;

  dma_prio_arb #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_rotate(cfg_rotate),
    .dreq(dreq), .hlda(hlda), .svc_done(svc_done), .hrq(hrq), .gnt_idx(gnt_idx), .ack_n(ack_n)
  );

  int errors = 0, checks = 0, cnt = 0, wd = 0, hrq_gaps = 0;
  int exp_q[$];
  logic in_svc = 1'b0, track_hrq = 1'b0;
  logic [1:0] svc_ch = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) hlda <= 1'b0;
    else hlda <= host_auto ? hrq : hlda_force;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      svc_done <= 1'b0; cnt <= 0; served_clr <= '0;
    end else begin
      svc_done <= 1'b0;
      if (clr_flush) served_clr <= '0;
      if (!(&ack_n) && !svc_done) begin
        if (cnt == SVC - 1) begin
          svc_done <= 1'b1;
          cnt <= 0;
          if (drop_mode) served_clr[gnt_idx] <= 1'b1;
        end else cnt <= cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (track_hrq && !hrq) hrq_gaps++;
      if (!(&ack_n)) begin
        if (!in_svc) begin
          in_svc = 1'b1;
          svc_ch = gnt_idx;
          if (exp_q.size() == 0) chk(0, "R3 R4 unexpected grant", gnt_idx, -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(gnt_idx == 2'(e), "R3 R4 grant order", gnt_idx, e);
            chk(ack_n == ~(4'b0001 << e), "R8 ack pattern", ack_n, ~(4'b0001 << e) & 4'hF);
          end
        end else chk(gnt_idx == svc_ch, "R5 grant held", gnt_idx, svc_ch);
        if (svc_done) in_svc = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=completion", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_req(logic [NCH-1:0] v);
    @(negedge clk); clr_flush = 1'b1;
    @(negedge clk); clr_flush = 1'b0; req_on = v;
  endtask

  task automatic cfg(logic [NCH-1:0] m, logic r);
    @(negedge clk); cfg_we = 1'b1; cfg_mask = m; cfg_rotate = r;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (!(exp_q.size() == 0 && !hrq && !hlda && !in_svc)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hrq == 1'b0, "R1 hrq in reset", hrq, 0);
    chk(&ack_n, "R1 ack in reset", ack_n, 15);
    rst_n = 1'b1;

    set_req(4'hF);
    repeat (6) @(negedge clk);
    chk(hrq == 1'b0, "R1 R7 masked after reset", hrq, 0);
    chk(&ack_n, "R1 R7 no ack while masked", ack_n, 15);
    set_req(4'h0);

    cfg(4'h0, 1'b0);
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
    set_req(4'hF);
    wait (in_svc);
    track_hrq = 1'b1;
    wait (exp_q.size() == 0);
    track_hrq = 1'b0;
    wait_quiet();
    chk(hrq_gaps == 0, "R9 hrq kept across back-to-back services", hrq_gaps, 0);
    chk(hrq == 1'b0, "R6 hrq released", hrq, 0);

    exp_q.push_back(3); exp_q.push_back(0);
    set_req(4'b1000);
    wait (in_svc);
    req_on[0] = 1'b1;
    @(negedge clk);
    chk(gnt_idx == 2'd3, "R5 no preemption idx", gnt_idx, 3);
    chk(ack_n == 4'b0111, "R5 no preemption ack", ack_n, 7);
    wait_quiet();

    cfg(4'h0, 1'b1);
    drop_mode = 1'b0;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(0);
    set_req(4'hF);
    wait (exp_q.size() == 0);
    req_on = '0;
    wait_quiet();
    drop_mode = 1'b1;

    exp_q.push_back(2); exp_q.push_back(0);
    set_req(4'b0101);
    wait_quiet();

    cfg(4'h0, 1'b0);
    exp_q.push_back(0); exp_q.push_back(2);
    set_req(4'b0101);
    wait_quiet();

    cfg(4'b0001, 1'b0);
    exp_q.push_back(1);
    set_req(4'b0011);
    wait_quiet();
    repeat (4) @(negedge clk);
    chk(hrq == 1'b0, "R7 masked request raises no hrq", hrq, 0);
    chk(&ack_n, "R7 masked channel not acked", ack_n, 15);
    cfg(4'h0, 1'b0);
    exp_q.push_back(0);
    wait_quiet();
    set_req(4'h0);

    host_auto = 1'b0; hlda_force = 1'b0;
    set_req(4'b0100);
    repeat (3) @(negedge clk);
    chk(hrq == 1'b1, "R2 hrq raised", hrq, 1);
    chk(&ack_n, "R2 no ack before hlda", ack_n, 15);
    exp_q.push_back(2);
    hlda_force = 1'b1;
    wait (in_svc);
    hlda_force = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(&ack_n, "R8 ack blanked while hlda low", ack_n, 15);
    chk(hrq == 1'b1, "R5 service kept during hlda drop", hrq, 1);
    hlda_force = 1'b1;
    @(negedge clk);
    while (hrq) @(negedge clk);
    set_req(4'b0010);
    repeat (4) @(negedge clk);
    chk(hrq == 1'b0, "R6 no new hrq while hlda high", hrq, 0);
    exp_q.push_back(1);
    host_auto = 1'b1;
    wait_quiet();
    chk(exp_q.size() == 0, "R6 request served after hlda release", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule